// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces one column address per beat for a read or write burst inside a single open row of a synchronous DRAM. A controller pulses the start strobe with the first column, the burst length code, the burst order and the single-write option taken from its copy of the mode register. From the next cycle on, the block presents one column per clock with a valid flag. On the final beat of a fixed-length burst it raises a done flag.

Fixed lengths of 1, 2, 4 and 8 wrap inside their naturally aligned block of columns. They follow either a sequential or an interleaved order. A full-page burst walks the whole row and wraps past the last column. It runs until a stop strobe or a new start arrives.

When the single-write option is set, a write command gets exactly one beat. Read commands keep the programmed length.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `valid_o` and `done_o` are low.
- R2: A start strobe sampled at a clock edge makes `valid_o` high in the following cycle, with `col_o` equal to the sampled start column.
- R3: Length code 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Code 7 selects full page. Codes 4, 5 and 6 give a single beat.
- R4: With `ilv_i` = 0 (sequential), beat i uses low bits (start + i) mod L inside the aligned block of L columns. The column bits above the block stay those of the start column. Example: L=4 from offset 1 gives 1-2-3-0.
- R5: With `ilv_i` = 1 (interleaved) and a fixed length L, beat i uses the start column's low log2(L) bits XOR i. The upper bits stay fixed.
- R6: A full-page burst steps the column sequentially modulo 2^COL_W, whatever the value of `ilv_i`. It never raises `done_o` and stays valid until stopped or restarted.
- R7: A stop strobe without a start ends the burst, so `valid_o` is low the next cycle. A stop with no burst in progress has no effect. A start sampled together with a stop wins.
- R8: With `wr_single_i` = 1, a start with `wr_i` = 1 yields one beat whatever the length code. A start with `wr_i` = 0 uses the programmed length. With `wr_single_i` = 0, writes burst like reads.
- R9: `done_o` is high exactly on the last beat of a fixed-length burst. For length 1, `valid_o` and `done_o` are high in the same cycle. `valid_o` is low on the cycle after done unless a new start was sampled.
- R10: A start sampled during an active burst abandons it, and the new burst's first column appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with the fields below |
| stop_i | input | 1 | End the burst in progress |
| wr_i | input | 1 | The starting command is a write |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| wr_single_i | input | 1 | Writes access a single column |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| done_o | output | 1 | Current beat is the last one |

## Verification
Directed bursts run each length from odd and even start offsets in both orders. These tell a wrap within the aligned block apart from a plain increment, and an XOR order apart from a rotation. A full-page burst started near the top of the row shows whether the whole column field wraps, and then a stop ends it. Further cases cover a restart in mid-burst, start and stop in the same cycle, reserved length codes, and writes with and without the single-write option. A random phase then mixes all of these against a queue-based model, compared on every cycle.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             done_o
);

  logic             active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic [2:0]       code_eff;

  assign code_eff = (wr_i && wr_single_i) ? 3'd0 : len_code_i;

  always_comb begin
    full_d = 1'b0;
    case (code_eff)
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      3'd7:    begin mask_d = '1; full_d = 1'b1; end
      default: mask_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_d;
      ilv_q    <= ilv_i;
      base_q   <= start_col_i;
      beat_q   <= '0;
      mask_q   <= mask_d;
    end else if (stop_i || done_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      beat_q   <= beat_q + 1'b1;
    end
  end

  logic [COL_W-1:0] seq_col, ilv_col;
  assign seq_col = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  assign ilv_col = base_q ^ beat_q;

  assign col_o   = full_q ? (base_q + beat_q) : (ilv_q ? ilv_col : seq_col);
  assign valid_o = active_q;
  assign done_o  = active_q && !full_q && (beat_q == mask_q);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !valid_o && !done_o);

  p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && col_o == $past(start_col_i));

  p_fullpage_nodone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_q) |-> !done_o);

  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o);

  p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !valid_o);

  p_done_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> valid_o);

  p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !done_o && !start_i && !stop_i) |=> valid_o && col_o[0] != $past(col_o[0]));

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int COL_W = 10;
  localparam int COLS  = 1 << COL_W;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, stop_i = 0, wr_i = 0, ilv_i = 0, wr_single_i = 0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic valid_o, done_o;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .wr_i(wr_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
    .wr_single_i(wr_single_i), .col_o(col_o), .valid_o(valid_o), .done_o(done_o));

  int vectors = 0, fails = 0;
  int q[$];
  bit fp = 0;
  int fp_base = 0, fp_i = 0;

  function automatic int burst_len(int code, bit wr, bit ws);
    if (wr && ws) return 1;
    case (code)
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic compare(string tag);
    bit ev, ed; int ec;
    ev = fp || (q.size() > 0);
    ed = !fp && (q.size() == 1);
    ec = fp ? (fp_base + fp_i) % COLS : (q.size() > 0 ? q[0] : 0);
    vectors++;
    if (valid_o !== ev || done_o !== ed || (ev && int'(col_o) != ec)) begin
      fails++;
      $display("FAIL %s: valid=%0b done=%0b col=%0d expected valid=%0b done=%0b col=%0d",
               tag, valid_o, done_o, col_o, ev, ed, ec);
    end
  endtask

  task automatic step(string tag, bit st, bit sp, bit wr, int col, int code, bit il, bit ws);
    @(negedge clk);
    compare(tag);
    start_i = st; stop_i = sp; wr_i = wr; start_col_i = COL_W'(col);
    len_code_i = 3'(code); ilv_i = il; wr_single_i = ws;
    if (st) begin
      q.delete(); fp = 0;
      if (code == 7 && !(wr && ws)) begin
        fp = 1; fp_base = col; fp_i = 0;
      end else begin
        int len = burst_len(code, wr, ws);
        int blk = col - (col % len);
        for (int i = 0; i < len; i++)
          q.push_back(il ? blk + ((col % len) ^ i) : blk + ((col % len + i) % len));
      end
    end else if (sp) begin
      q.delete(); fp = 0;
    end else if (fp) fp_i++;
    else if (q.size() > 0) void'(q.pop_front());
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); compare("R1 in reset");
    rst_n = 1;
    idle("R1 idle after reset", 3);
    // R2 R3 R4 sequential lengths from odd offsets
    step("R2", 1, 0, 0, 13, 0, 0, 0); idle("R3 len1", 2);
    step("R4", 1, 0, 0, 13, 1, 0, 0); idle("R4 len2", 3);
    step("R4", 1, 0, 0, 13, 2, 0, 0); idle("R4 len4 1-2-3-0", 5);
    step("R4", 1, 0, 0, 11, 3, 0, 0); idle("R4 len8 3..2", 9);
    // R5 interleaved
    step("R5", 1, 0, 0, 13, 2, 1, 0); idle("R5 len4", 5);
    step("R5", 1, 0, 0, 46, 3, 1, 0); idle("R5 len8", 9);
    // R3 reserved codes
    step("R3", 1, 0, 0, 7, 4, 0, 0); idle("R3 code4", 2);
    step("R3", 1, 0, 0, 7, 6, 1, 0); idle("R3 code6", 2);
    // R6 full page wraps the row, then R7 stop
    step("R6", 1, 0, 0, COLS - 3, 7, 1, 0); idle("R6 full page wrap", 10);
    step("R7 stop", 0, 1, 0, 0, 0, 0, 0); idle("R7 after stop", 3);
    step("R7 idle stop", 0, 1, 0, 0, 0, 0, 0); idle("R7 idle stop", 2);
    // R10 restart mid burst, R7 start beats stop
    step("R10", 1, 0, 0, 20, 3, 0, 0); idle("R10", 3);
    step("R10 restart", 1, 0, 0, 101, 2, 0, 0); idle("R10 new burst", 5);
    step("R7 start+stop", 1, 1, 0, 33, 1, 0, 0); idle("R7 start wins", 3);
    // R8 write single mode
    step("R8 wr single", 1, 0, 1, 50, 3, 0, 1); idle("R8 one beat", 3);
    step("R8 rd bursts", 1, 0, 0, 50, 3, 0, 1); idle("R8 read len8", 9);
    step("R8 wr burst", 1, 0, 1, 50, 2, 0, 0); idle("R8 write len4", 5);
    step("R8 wr fullpage", 1, 0, 1, 5, 7, 0, 1); idle("R8 wr single over full page", 3);
    // R9 back-to-back on done
    step("R9", 1, 0, 0, 2, 1, 0, 0); step("R9", 0, 0, 0, 0, 0, 0, 0);
    step("R9 start on done", 1, 0, 0, 9, 0, 0, 0); idle("R9 len1", 2);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      step("R4 R5 R6 R10 random", r < 15, r >= 15 && r < 20, $urandom_range(0, 1),
           $urandom_range(0, COLS - 1), $urandom_range(0, 7), $urandom_range(0, 1),
           $urandom_range(0, 1));
    end
    idle("R9 drain", 10);
    step("R7 final stop", 0, 1, 0, 0, 0, 0, 0); idle("R1 end", 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule